// File: doc/BRIEF.md
# Four-Way Address Translation Buffer with Pseudo-Random Refill Hint

This block caches page translations for a 32-bit virtual address space with 8 KB pages. It has four ways, each holding sixteen entries. Bits [16:13] of the virtual address pick the index, so they are the low four bits of the virtual page number. On each lookup all four ways at that index are compared at once. An entry hits when it is valid, its virtual page number matches, and either it is marked global or its address-space tag equals the requester's 8-bit process ID. A separate write port lets software place a hi word (page number and process tag) and a lo word (frame number and attribute bits) into any way and index.

A lookup is answered one cycle after it is presented. The answer is one of three outcomes:

- **Hit:** the physical frame number is returned.
- **Protection fault:** a kernel-only entry was reached from user mode while kernel protection is on.
- **Refill miss:** no entry matches.

Both faults and misses advance a 16-bit linear feedback shift register. On a miss, the low two bits of that register, taken before the advance, name the way software should overwrite. The refill-select output then holds that way together with the index. This spreads refills across all four ways instead of always reusing one.

Top module: `refill_tlb`

## Requirements
- R1: A write (wrEn) stores wrHi/wrLo into way wrWay at index wrIndex. A lookup presented in the same cycle as a write still sees the old entry; later lookups see the new one.
- R2: An entry matches a lookup when all of the following hold: its valid bit (lo bit 3) is set; its page number (hi bits [31:13]) equals reqVaddr[31:13]; and either its global bit (lo bit 4) is set or its tag (hi bits [7:0]) equals reqPid. The index used is reqVaddr[16:13].
- R3: On a hit, in the cycle after the request, rspValid=1, rspHit=1, rspFault=0 and rspFrame holds lo bits [31:13] of the matching entry. Whenever rspHit is 0, rspFrame is 0.
- R4: When several ways match, the lowest-numbered way supplies the result.
- R5: When the matching entry has its kernel-only bit (lo bit 2) set, reqUser=1 and kprotEn=1, the response is rspFault=1 and rspHit=0 instead of a hit.
- R6: The hint register resets to 0xCCCC. It advances once for every miss and every protection fault, and never on a hit or an idle cycle. To advance, it shifts right by one and puts the parity of its bits 15, 11, 2 and 0 into bit 15.
- R7: On a miss (rspValid=1, rspHit=0, rspFault=0), refillSel is loaded with the index in bits [3:0] and the hint register's low two bits, taken before the advance, in bits [5:4].
- R8: On a protection fault, refillSel is loaded with the index in bits [3:0] and the matching way in bits [5:4].
- R9: A hit leaves refillSel unchanged.
- R10: After reset, rspValid, rspHit, rspFault, rspFrame and refillSel are 0, and every entry is invalid, so the first lookup misses.
- R11: In the cycle after a cycle with no request, rspValid, rspHit and rspFault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqPid | input | 8 | Current process ID |
| reqUser | input | 1 | 1 = user-mode access |
| kprotEn | input | 1 | Kernel-only protection enable |
| wrEn | input | 1 | Entry write strobe |
| wrWay | input | 2 | Way to write |
| wrIndex | input | 4 | Index to write |
| wrHi | input | 32 | Hi word: page number [31:13], tag [7:0] |
| wrLo | input | 32 | Lo word: frame [31:13], global 4, valid 3, kernel-only 2 |
| rspValid | output | 1 | Response present (request one cycle earlier) |
| rspHit | output | 1 | Translation hit |
| rspFault | output | 1 | Kernel-protection fault |
| rspFrame | output | 19 | Physical frame number on hit, else 0 |
| refillSel | output | 6 | Refill select: way [5:4], index [3:0] |

## Verification
The bench writes an entry in the same cycle it looks that entry up. A design that bypasses the write would return a hit one cycle too early. It fills several ways at one index with matching entries: an encoder that favours the highest way returns the wrong frame. It swaps process tags and toggles the global and valid bits: a compare that ignores either bit gives hits where misses belong. It predicts the full sequence of suggested ways over hundreds of misses and faults. A wrong tap, a missed advance on protection faults, an advance on hits, or sampling the register after the advance would each send refillSel[5:4] off the predicted sequence.

// File: rtl/refill_tlb_pkg.sv
package refill_tlb_pkg;
  parameter int unsigned TLB_WAYS  = 4;
  parameter int unsigned TLB_SETS  = 16;
  parameter int unsigned VA_W      = 32;
  parameter int unsigned PAGE_BITS = 13;
  parameter int unsigned PID_W     = 8;
  parameter int unsigned LFSR_W    = 16;
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hCCCC;
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805;

  // lo-word attribute bit positions (software-visible encoding)
  parameter int unsigned LO_G_BIT = 4;
  parameter int unsigned LO_V_BIT = 3;
  parameter int unsigned LO_K_BIT = 2;

  localparam int unsigned WAY_W = $clog2(TLB_WAYS);
  localparam int unsigned IDX_W = $clog2(TLB_SETS);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;
  localparam int unsigned SEL_W = IDX_W + WAY_W;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] pfn;
    logic             glob;
    logic             valid;
    logic             kern;
  } tlbEntry_t;

  typedef struct packed {
    logic             hit;
    logic             fault;
    logic             miss;
    logic [WAY_W-1:0] way;
  } tlbStrobes_t;
endpackage

// File: rtl/refill_tlb_ctrl.sv
module refill_tlb_ctrl
  import refill_tlb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqUser,
  input  logic                kprotEn,
  input  logic [TLB_WAYS-1:0] matchVec,
  input  logic [TLB_WAYS-1:0] kernVec,
  output tlbStrobes_t         strobes
);
  logic             found;
  logic [WAY_W-1:0] pickWay;
  logic             protViolation;

  // lowest-numbered matching way wins: scan downward, last assignment sticks
  always_comb begin
    found   = 1'b0;
    pickWay = '0;
    for (int w = TLB_WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) begin
        found   = 1'b1;
        pickWay = WAY_W'(w);
      end
    end
  end

  assign protViolation = kprotEn && reqUser && kernVec[pickWay];

  always_comb begin
    strobes.hit   = reqValid && found && !protViolation;
    strobes.fault = reqValid && found && protViolation;
    strobes.miss  = reqValid && !found;
    strobes.way   = pickWay;
  end

  p_outcome_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.hit, strobes.fault, strobes.miss}));

  p_miss_no_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.miss |-> (matchVec == '0));

  p_lowest_way_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hit || strobes.fault) |->
      (matchVec[strobes.way] && ((matchVec & ~({TLB_WAYS{1'b1}} << strobes.way)) == '0)));

  p_fault_needs_user_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fault |-> (reqUser && kprotEn));
endmodule

// File: rtl/refill_tlb_dpath.sv
module refill_tlb_dpath
  import refill_tlb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [PID_W-1:0]    reqPid,
  input  logic                wrEn,
  input  logic [WAY_W-1:0]    wrWay,
  input  logic [IDX_W-1:0]    wrIndex,
  input  logic [VA_W-1:0]     wrHi,
  input  logic [VA_W-1:0]     wrLo,
  input  tlbStrobes_t         strobes,
  output logic [TLB_WAYS-1:0] matchVec,
  output logic [TLB_WAYS-1:0] kernVec,
  output logic                rspValid,
  output logic                rspHit,
  output logic                rspFault,
  output logic [VPN_W-1:0]    rspFrame,
  output logic [SEL_W-1:0]    refillSel
);
  tlbEntry_t        tblQ [TLB_WAYS][TLB_SETS];
  tlbEntry_t        wrEntry;
  logic [IDX_W-1:0] reqIdx;
  logic [VPN_W-1:0] reqVpn;
  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrNext;
  logic             unusedBits;

  assign unusedBits = ^{reqVaddr[PAGE_BITS-1:0], wrHi[PAGE_BITS-1:PID_W],
                        wrLo[PAGE_BITS-1:LO_G_BIT+1], wrLo[LO_K_BIT-1:0]};

  assign reqIdx = reqVaddr[PAGE_BITS +: IDX_W];
  assign reqVpn = reqVaddr[VA_W-1:PAGE_BITS];

  always_comb begin
    wrEntry.vpn   = wrHi[VA_W-1:PAGE_BITS];
    wrEntry.pid   = wrHi[PID_W-1:0];
    wrEntry.pfn   = wrLo[VA_W-1:PAGE_BITS];
    wrEntry.glob  = wrLo[LO_G_BIT];
    wrEntry.valid = wrLo[LO_V_BIT];
    wrEntry.kern  = wrLo[LO_K_BIT];
  end

  // entry storage: a same-cycle write is visible only from the next cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < TLB_WAYS; w++)
        for (int s = 0; s < TLB_SETS; s++)
          tblQ[w][s] <= '0;
    end else if (wrEn) begin
      tblQ[wrWay][wrIndex] <= wrEntry;
    end
  end

  // one comparator per way
  for (genvar w = 0; w < TLB_WAYS; w++) begin : g_way
    tlbEntry_t ent;
    assign ent         = tblQ[w][reqIdx];
    assign matchVec[w] = ent.valid && (ent.vpn == reqVpn) &&
                         (ent.glob || (ent.pid == reqPid));
    assign kernVec[w]  = ent.kern;
  end

  assign lfsrNext = {^(lfsrQ & LFSR_TAPS), lfsrQ[LFSR_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspFault  <= 1'b0;
      rspFrame  <= '0;
      refillSel <= '0;
      lfsrQ     <= LFSR_SEED;
    end else begin
      rspValid <= reqValid;
      rspHit   <= strobes.hit;
      rspFault <= strobes.fault;
      rspFrame <= strobes.hit ? tblQ[strobes.way][reqIdx].pfn : '0;
      if (strobes.miss)
        refillSel <= {lfsrQ[WAY_W-1:0], reqIdx};
      else if (strobes.fault)
        refillSel <= {strobes.way, reqIdx};
      if (strobes.miss || strobes.fault)
        lfsrQ <= lfsrNext;
    end
  end

  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  p_lfsr_hold_on_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> $stable(lfsrQ));

  p_sel_hold_on_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> $stable(refillSel));

  p_sel_index_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !strobes.hit) |=> (refillSel[IDX_W-1:0] == $past(reqIdx)));

  p_frame_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspFrame == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && !rspFault));
endmodule

// File: rtl/refill_tlb.sv
module refill_tlb
  import refill_tlb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [VA_W-1:0]      reqVaddr,
  input  logic [PID_W-1:0]     reqPid,
  input  logic                 reqUser,
  input  logic                 kprotEn,
  input  logic                 wrEn,
  input  logic [WAY_W-1:0]     wrWay,
  input  logic [IDX_W-1:0]     wrIndex,
  input  logic [VA_W-1:0]      wrHi,
  input  logic [VA_W-1:0]      wrLo,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic                 rspFault,
  output logic [VPN_W-1:0]     rspFrame,
  output logic [SEL_W-1:0]     refillSel
);
  tlbStrobes_t         strobes;
  logic [TLB_WAYS-1:0] matchVec;
  logic [TLB_WAYS-1:0] kernVec;

  refill_tlb_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqUser  (reqUser),
    .kprotEn  (kprotEn),
    .matchVec (matchVec),
    .kernVec  (kernVec),
    .strobes  (strobes)
  );

  refill_tlb_dpath dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqVaddr  (reqVaddr),
    .reqPid    (reqPid),
    .wrEn      (wrEn),
    .wrWay     (wrWay),
    .wrIndex   (wrIndex),
    .wrHi      (wrHi),
    .wrLo      (wrLo),
    .strobes   (strobes),
    .matchVec  (matchVec),
    .kernVec   (kernVec),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspFault  (rspFault),
    .rspFrame  (rspFrame),
    .refillSel (refillSel)
  );
endmodule

// File: tb/refill_tlb_tb_top.sv
`timescale 1ns/1ps
module refill_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [7:0]  reqPid = '0;
  logic        reqUser = 1'b0;
  logic        kprotEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrWay = '0;
  logic [3:0]  wrIndex = '0;
  logic [31:0] wrHi = '0;
  logic [31:0] wrLo = '0;
  logic        rspValid, rspHit, rspFault;
  logic [18:0] rspFrame;
  logic [5:0]  refillSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refill_tlb dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqPid(reqPid), .reqUser(reqUser), .kprotEn(kprotEn), .wrEn(wrEn),
    .wrWay(wrWay), .wrIndex(wrIndex), .wrHi(wrHi), .wrLo(wrLo),
    .rspValid(rspValid), .rspHit(rspHit), .rspFault(rspFault),
    .rspFrame(rspFrame), .refillSel(refillSel)
  );

  typedef struct {
    bit          v;
    bit          h;
    bit          f;
    logic [18:0] fr;
    logic [5:0]  sel;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference model state
  logic [31:0] mHi [4][16];
  logic [31:0] mLo [4][16];
  logic [15:0] mLfsr;
  logic [5:0]  mSel;

  function automatic logic [31:0] mkHi(input logic [18:0] vpn, input logic [7:0] pid);
    return {vpn, 5'd0, pid};
  endfunction

  function automatic logic [31:0] mkLo(input logic [18:0] pfn, input bit g, input bit v, input bit k);
    return {pfn, 8'd0, g, v, k, 2'b00};
  endfunction

  task automatic step(input bit doReq, input logic [31:0] va, input logic [7:0] pid,
                      input bit user, input bit kp, input bit doWr, input logic [1:0] wway,
                      input logic [3:0] widx, input logic [31:0] hi, input logic [31:0] lo,
                      input string tag);
    expItem_t e;
    logic [3:0] idx;
    bit found;
    int way;
    @(negedge clk);
    reqValid = doReq; reqVaddr = va; reqPid = pid; reqUser = user; kprotEn = kp;
    wrEn = doWr; wrWay = wway; wrIndex = widx; wrHi = hi; wrLo = lo;
    idx = va[16:13];
    found = 1'b0; way = 0;
    for (int w = 0; w < 4; w++) begin
      if (!found && mLo[w][idx][3] && mHi[w][idx][31:13] == va[31:13] &&
          (mLo[w][idx][4] || mHi[w][idx][7:0] == pid)) begin
        found = 1'b1; way = w;
      end
    end
    e.v = doReq; e.h = 1'b0; e.f = 1'b0; e.fr = '0;
    e.tag = tag;
    if (doReq) begin
      if (found && kp && user && mLo[way][idx][2]) begin
        e.f = 1'b1;
        mSel = {2'(way), idx};
        mLfsr = {mLfsr[15] ^ mLfsr[11] ^ mLfsr[2] ^ mLfsr[0], mLfsr[15:1]};
        if (tag == "") e.tag = "R5/R8";
      end else if (found) begin
        e.h = 1'b1;
        e.fr = mLo[way][idx][31:13];
        if (tag == "") e.tag = "R3/R9";
      end else begin
        mSel = {mLfsr[1:0], idx};
        mLfsr = {mLfsr[15] ^ mLfsr[11] ^ mLfsr[2] ^ mLfsr[0], mLfsr[15:1]};
        if (tag == "") e.tag = "R6/R7";
      end
    end else if (tag == "") e.tag = "R11";
    e.sel = mSel;
    expQ.push_back(e);
    if (doWr) begin
      mHi[wway][widx] = hi;
      mLo[wway][widx] = lo;
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] pid, input bit user,
                        input bit kp, input string tag);
    step(1'b1, va, pid, user, kp, 1'b0, 2'd0, 4'd0, 32'd0, 32'd0, tag);
  endtask

  task automatic write(input logic [1:0] w, input logic [3:0] i, input logic [31:0] hi,
                       input logic [31:0] lo);
    step(1'b0, 32'd0, 8'd0, 1'b0, 1'b0, 1'b1, w, i, hi, lo, "R11");
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'd0, 8'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 32'd0, 32'd0, tag);
  endtask

  // monitor: one expected item per driven cycle, sampled after the edge
  always @(posedge clk) begin
    expItem_t e;
    #1;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      checks++;
      if (rspValid !== e.v || rspHit !== e.h || rspFault !== e.f ||
          rspFrame !== e.fr || refillSel !== e.sel) begin
        errors++;
        $display("FAIL %s: got v=%0b h=%0b f=%0b frame=%h sel=%h expected v=%0b h=%0b f=%0b frame=%h sel=%h",
                 e.tag, rspValid, rspHit, rspFault, rspFrame, refillSel,
                 e.v, e.h, e.f, e.fr, e.sel);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [18:0] VA = 19'h12345;  // index 5
  localparam logic [18:0] VB = 19'h0ABC5;  // same index 5, different page

  initial begin
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 16; s++) begin mHi[w][s] = '0; mLo[w][s] = '0; end
    mLfsr = 16'hCCCC;
    mSel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10: reset state at the ports
    checks++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0 || rspFault !== 1'b0 ||
        rspFrame !== '0 || refillSel !== '0) begin
      errors++;
      $display("FAIL R10: got v=%0b h=%0b f=%0b frame=%h sel=%h expected all zero",
               rspValid, rspHit, rspFault, rspFrame, refillSel);
    end
    // R10: cleared table misses even for page 0 / pid 0
    lookup(32'h0, 8'h0, 1'b0, 1'b0, "R10");
    lookup({VA, 13'h0}, 8'h07, 1'b0, 1'b0, "R10");
    idle("R11");
    // R1: write and lookup in the same cycle -> still a miss; next cycle hits
    step(1'b1, {VA, 13'h1F0}, 8'h07, 1'b0, 1'b0, 1'b1, 2'd2, 4'd5,
         mkHi(VA, 8'h07), mkLo(19'h7AAAA, 1'b0, 1'b1, 1'b0), "R1");
    lookup({VA, 13'h1F0}, 8'h07, 1'b0, 1'b0, "R1");
    lookup({VA, 13'h004}, 8'h07, 1'b1, 1'b1, "R3");
    // R2: wrong pid misses, global bit overrides pid
    lookup({VA, 13'h0}, 8'h08, 1'b0, 1'b0, "R2");
    write(2'd0, 4'd5, mkHi(VB, 8'h33), mkLo(19'h11111, 1'b1, 1'b1, 1'b0));
    lookup({VB, 13'h0}, 8'h99, 1'b0, 1'b0, "R2");
    // R2: invalid entry with matching fields misses
    write(2'd1, 4'd6, mkHi(19'h00006, 8'h01), mkLo(19'h22222, 1'b1, 1'b0, 1'b0));
    lookup({19'h00006, 13'h0}, 8'h01, 1'b0, 1'b0, "R2");
    // R4: ways 1 and 3 both match; way 1 wins
    write(2'd3, 4'd7, mkHi(19'h00017, 8'h05), mkLo(19'h33333, 1'b0, 1'b1, 1'b0));
    write(2'd1, 4'd7, mkHi(19'h00017, 8'h05), mkLo(19'h44444, 1'b0, 1'b1, 1'b0));
    lookup({19'h00017, 13'h0}, 8'h05, 1'b0, 1'b0, "R4");
    // R5/R8: kernel-only entry in way 3
    write(2'd3, 4'd9, mkHi(19'h00029, 8'h05), mkLo(19'h55555, 1'b0, 1'b1, 1'b1));
    lookup({19'h00029, 13'h0}, 8'h05, 1'b1, 1'b1, "R5/R8");
    lookup({19'h00029, 13'h0}, 8'h05, 1'b1, 1'b0, "R5");
    lookup({19'h00029, 13'h0}, 8'h05, 1'b0, 1'b1, "R5");
    // R9: hit after a miss keeps refillSel
    lookup({19'h7FFFF, 13'h0}, 8'h05, 1'b0, 1'b0, "R7");
    lookup({19'h00017, 13'h0}, 8'h05, 1'b0, 1'b0, "R9");
    idle("R11");
    idle("R11");
    // R6/R7: long miss run walks the hint sequence
    for (int i = 0; i < 40; i++)
      lookup({4'hF, 11'(i), 4'(i), 13'h0}, 8'h42, 1'b0, 1'b0, "R6/R7");
    // randomized fills and lookups over a small page pool
    for (int i = 0; i < 500; i++) begin
      logic [18:0] vpn;
      logic [7:0]  pid;
      vpn = {13'h0155, 2'($urandom % 4), 4'($urandom % 16)};
      pid = ($urandom % 2) ? 8'h03 : 8'h07;
      case ($urandom % 4)
        0: write(2'($urandom % 4), vpn[3:0], mkHi(vpn, pid),
                 mkLo(19'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 8 != 0),
                      1'($urandom % 3 == 0)));
        1: idle("");
        default: lookup({vpn, 13'($urandom)}, pid, 1'($urandom % 2),
                        1'($urandom % 2), "");
      endcase
    end
    idle("R11");
    idle("R11");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule